// File: doc/BRIEF.md
# Seven-slot pixel serializer for a four-lane LVDS display link

The block turns one parallel pixel into seven serial bit slots. The pixel has red, green and blue at 8 bits each, plus horizontal sync, vertical sync, data enable and one spare control bit. It runs on the fast bit clock, which is seven times the pixel rate. In every slot it drives one bit on each of up to four data lanes. It also drives a clock lane whose level repeats once per pixel. An upstream pixel source watches `load_o`. It must present the next pixel in the cycle where that strobe is high, and the block captures the pixel at the edge that opens slot 0.

The mode input selects one of three bit placements:

- Mode 0 is an 18-bit mapping on three lanes with 6-bit colours.
- Mode 1 is a 24-bit mapping that puts the upper six bits of each colour on lanes 0 to 2 and the two lowest bits on lane 3.
- Mode 2 is a 24-bit mapping that keeps the 18-bit placement on lanes 0 to 2 and adds the two highest bits on lane 3.

The mode is taken only around reset, so the placement never changes inside a pixel.

Top module: `lvds_ser71`

## Requirements
- R1: Slots run 0,1,...,6 and wrap to 0, one per clock. The clock lane is high in slots 0, 1, 5 and 6 and low in slots 2, 3 and 4. After reset release, the first cycle showing slot 6 is the sixth cycle.
- R2: `load_o` is high exactly in slot 6. The pixel inputs are sampled at the edge that ends that cycle, and that pixel's slot 0 appears in the following cycle.
- R3: Mode 0 (encoding 2'd0), listed per lane as the bit in slot 0 through slot 6. Control bits are C0=hsync_i, C1=vsync_i, C2=de_i and C3=spare_i.
  - lane 0: G0 R5 R4 R3 R2 R1 R0
  - lane 1: B1 B0 G5 G4 G3 G2 G1
  - lane 2: C2 C1 C0 B5 B4 B3 B2
- R4: In mode 0, lane 3 stays low and colour bits 7:6 have no effect on any lane.
- R5: Mode 1 (encoding 2'd1), lanes 0 to 2, slot 0 through slot 6:
  - lane 0: G2 R7 R6 R5 R4 R3 R2
  - lane 1: B3 B2 G7 G6 G5 G4 G3
  - lane 2: C2 C1 C0 B7 B6 B5 B4
- R6: Mode 1, lane 3, slot 0 through slot 6: C3 B1 B0 G1 G0 R1 R0.
- R7: In mode 2 (encoding 2'd2), lanes 0 to 2 carry the R3 placement using colour bits 5..0.
- R8: Mode 2, lane 3, slot 0 through slot 6: C3 B7 B6 G7 G6 R7 R6.
- R9: `mode_i` is taken at every edge while reset is low and at the first edge after release. Later changes have no effect until the next reset. Encoding 2'd3 behaves as mode 0.
- R10: While reset is low, the block is in slot 0 with all data lanes low, the clock lane high and `load_o` low. An asserted reset takes effect at once, even in the middle of a pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | bit clock, seven cycles per pixel |
| rst_ni | input | 1 | asynchronous reset, active low |
| mode_i | input | 2 | bit placement select, taken around reset |
| red_i | input | 8 | red component |
| grn_i | input | 8 | green component |
| blu_i | input | 8 | blue component |
| hsync_i | input | 1 | horizontal sync (C0) |
| vsync_i | input | 1 | vertical sync (C1) |
| de_i | input | 1 | data enable (C2) |
| spare_i | input | 1 | spare control bit (C3) |
| load_o | output | 1 | high in slot 6: pixel inputs are sampled at the end of this cycle |
| lane_o | output | 4 | serial data lanes, one bit per slot |
| clk_lane_o | output | 1 | clock lane pattern |

## Verification
Capture of the next pixel and output of the previous pixel's last slot fall in the same cycle, because the new word is loaded while slot 6 of the old one is still on the lanes. The bench sends back-to-back pixels with unrelated bit patterns and changes every input exactly in the strobe cycle. The scoreboard then requires slot 6 to carry the old pixel and the next cycle's slot 0 to carry the new one. A reset pulse is also dropped into the middle of a pixel and mode changes are made while running. These check that the pending word is discarded and that the placement only follows the mode held at reset.

// File: rtl/lvds_ser_pkg.sv
package lvds_ser_pkg;
  localparam int unsigned COLOR_W   = 8;
  localparam int unsigned CTL_W     = 4;
  localparam int unsigned NUM_LANES = 4;
  localparam int unsigned NUM_SLOTS = 7;
  localparam int unsigned SLOT_W    = $clog2(NUM_SLOTS);
  localparam int unsigned NARROW_W  = 6;

  // bit s = clock lane level in slot s
  localparam logic [NUM_SLOTS-1:0] CLK_PATTERN = 7'b1100011;

  typedef enum logic [1:0] {
    MAP_18     = 2'd0,
    MAP_24_LO4 = 2'd1,
    MAP_24_HI4 = 2'd2,
    MAP_RSV    = 2'd3
  } map_mode_e;
endpackage

// File: rtl/lvds_slot_ctr.sv
module lvds_slot_ctr #(
  parameter int unsigned SLOTS  = 7,
  parameter int unsigned SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [SLOT_W-1:0] slot_o,
  output logic              last_o
);
  logic [SLOT_W-1:0] slot_q;

  assign last_o = (slot_q == SLOT_W'(SLOTS - 1));
  assign slot_o = slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     slot_q <= '0;
    else if (last_o) slot_q <= '0;
    else             slot_q <= slot_q + SLOT_W'(1);
  end
endmodule

// File: rtl/lvds_bit_map.sv
module lvds_bit_map
  import lvds_ser_pkg::*;
#(
  parameter int unsigned CW    = COLOR_W,
  parameter int unsigned NW    = NARROW_W,
  parameter int unsigned LANES = NUM_LANES,
  parameter int unsigned SLOTS = NUM_SLOTS
) (
  input  map_mode_e                     mode_i,
  input  logic [CW-1:0]                 red_i,
  input  logic [CW-1:0]                 grn_i,
  input  logic [CW-1:0]                 blu_i,
  input  logic [CTL_W-1:0]              ctl_i,
  output logic [LANES-1:0][SLOTS-1:0]   words_o
);
  logic          wide, hi4, quad;
  logic [NW-1:0] r6, g6, b6;
  logic [1:0]    rp, gp, bp;

  always_comb begin
    wide = (mode_i == MAP_24_LO4);
    hi4  = (mode_i == MAP_24_HI4);
    quad = wide | hi4;
    // six bits on lanes 0..2: upper slice in mode 1, lower slice otherwise
    r6 = wide ? red_i[CW-1 -: NW] : red_i[NW-1:0];
    g6 = wide ? grn_i[CW-1 -: NW] : grn_i[NW-1:0];
    b6 = wide ? blu_i[CW-1 -: NW] : blu_i[NW-1:0];
    // the pair left over for lane 3
    rp = hi4 ? red_i[CW-1 -: 2] : red_i[1:0];
    gp = hi4 ? grn_i[CW-1 -: 2] : grn_i[1:0];
    bp = hi4 ? blu_i[CW-1 -: 2] : blu_i[1:0];

    words_o    = '0;
    // bit index = slot number
    words_o[0] = {r6[0], r6[1], r6[2], r6[3], r6[4], r6[5], g6[0]};
    words_o[1] = {g6[1], g6[2], g6[3], g6[4], g6[5], b6[0], b6[1]};
    words_o[2] = {b6[2], b6[3], b6[4], b6[5], ctl_i[0], ctl_i[1], ctl_i[2]};
    if (quad)
      words_o[3] = {rp[0], rp[1], gp[0], gp[1], bp[0], bp[1], ctl_i[3]};
  end
endmodule

// File: rtl/lvds_slot_mux.sv
module lvds_slot_mux #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned SLOTS  = 7,
  parameter int unsigned SLOT_W = $clog2(SLOTS)
) (
  input  logic [LANES-1:0][SLOTS-1:0] words_i,
  input  logic [SLOT_W-1:0]           slot_i,
  output logic [LANES-1:0]            lane_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_o[l] = words_i[l][slot_i];
  end
endmodule

// File: rtl/lvds_ser71.sv
module lvds_ser71
  import lvds_ser_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           mode_i,
  input  logic [COLOR_W-1:0]   red_i,
  input  logic [COLOR_W-1:0]   grn_i,
  input  logic [COLOR_W-1:0]   blu_i,
  input  logic                 hsync_i,
  input  logic                 vsync_i,
  input  logic                 de_i,
  input  logic                 spare_i,
  output logic                 load_o,
  output logic [NUM_LANES-1:0] lane_o,
  output logic                 clk_lane_o
);
  logic [SLOT_W-1:0]                    slot;
  logic                                 last;
  logic                                 run_q;
  map_mode_e                            mode_q;
  logic [NUM_LANES-1:0][NUM_SLOTS-1:0]  words_d, words_q;

  lvds_slot_ctr #(.SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .slot_o (slot),
    .last_o (last)
  );

  // run_q stays low through the first edge after release; mode follows input until then
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (!run_q) mode_q <= (mode_i == MAP_RSV) ? MAP_18 : map_mode_e'(mode_i);
  end

  lvds_bit_map #(
    .CW(COLOR_W), .NW(NARROW_W), .LANES(NUM_LANES), .SLOTS(NUM_SLOTS)
  ) u_map (
    .mode_i  (mode_q),
    .red_i   (red_i),
    .grn_i   (grn_i),
    .blu_i   (blu_i),
    .ctl_i   ({spare_i, de_i, vsync_i, hsync_i}),
    .words_o (words_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   words_q <= '0;
    else if (last) words_q <= words_d;
  end

  lvds_slot_mux #(.LANES(NUM_LANES), .SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_mux (
    .words_i (words_q),
    .slot_i  (slot),
    .lane_o  (lane_o)
  );

  assign clk_lane_o = CLK_PATTERN[slot];
  assign load_o     = last & rst_ni;
endmodule

// File: rtl/lvds_ser71_chk.sv
module lvds_ser71_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] lane_o,
  input logic       clk_lane_o,
  input logic       load_o,
  input logic [1:0] mode_q,
  input logic       run_q
);
  logic [2:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     gap_q <= '0;
    else if (load_o) gap_q <= '0;
    else             gap_q <= gap_q + 3'd1;
  end

  a_r1_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o == (gap_q == 3'd6));
  a_r1_low_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_lane_o) |=> !clk_lane_o);
  a_r1_high_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_lane_o) |=> clk_lane_o);
  a_r2_load_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> clk_lane_o);
  a_r2_load_then_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> clk_lane_o && !load_o);
  a_r4_lane3_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 2'd0) |-> !lane_o[3]);
  a_r9_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |=> $stable(mode_q));
  a_r10_reset_state: assert property (@(posedge clk_i)
    !rst_ni |-> (lane_o == 4'b0) && clk_lane_o && !load_o);
endmodule

bind lvds_ser71 lvds_ser71_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .lane_o     (lane_o),
  .clk_lane_o (clk_lane_o),
  .load_o     (load_o),
  .mode_q     (mode_q),
  .run_q      (run_q)
);

// File: tb/lvds_ser71_bench.sv
module lvds_ser71_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic [7:0] red_i = '0, grn_i = '0, blu_i = '0;
  logic       hsync_i = 1'b0, vsync_i = 1'b0, de_i = 1'b0, spare_i = 1'b0;
  logic       load_o, clk_lane_o;
  logic [3:0] lane_o;

  typedef struct packed {
    logic [3:0] lanes;
    logic       clk;
    logic       load;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  string tag3_q[$];
  int    total = 0;
  int    bad   = 0;
  int    cur_mode = 0;

  lvds_ser71 u_lvds_ser71 (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i),
    .red_i(red_i), .grn_i(grn_i), .blu_i(blu_i),
    .hsync_i(hsync_i), .vsync_i(vsync_i), .de_i(de_i), .spare_i(spare_i),
    .load_o(load_o), .lane_o(lane_o), .clk_lane_o(clk_lane_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // independent model of the slot tables
  function automatic logic exp_bit(int m, int lane, int s,
                                   logic [7:0] r, logic [7:0] g, logic [7:0] b,
                                   logic [3:0] c);
    int o, h;
    o = (m == 1) ? 2 : 0;
    h = (m == 2) ? 6 : 0;
    case (lane)
      0: return (s == 0) ? g[o] : r[6+o-s];
      1: if (s == 0) return b[1+o];
         else if (s == 1) return b[o];
         else return g[7+o-s];
      2: return (s < 3) ? c[2-s] : b[8+o-s];
      default: begin
        if (m == 0) return 1'b0;
        case (s)
          0: return c[3];
          1: return b[h+1];
          2: return b[h];
          3: return g[h+1];
          4: return g[h];
          5: return r[h+1];
          default: return r[h];
        endcase
      end
    endcase
  endfunction

  // monitor: compare well after the active edge
  always begin
    @(posedge clk_i);
    #2;
    if (rst_ni && exp_q.size() > 0) begin
      exp_t  e;
      string t, t3;
      e  = exp_q.pop_front();
      t  = tag_q.pop_front();
      t3 = tag3_q.pop_front();
      chk("R1", "clock lane", 32'(clk_lane_o), 32'(e.clk));
      chk("R2", "load strobe", 32'(load_o), 32'(e.load));
      chk(t, "lanes 0..2", 32'(lane_o[2:0]), 32'(e.lanes[2:0]));
      chk(t3, "lane 3", 32'(lane_o[3]), 32'(e.lanes[3]));
    end
  end

  task automatic do_reset(input logic [1:0] m);
    int n;
    @(negedge clk_i);
    rst_ni = 1'b0;
    mode_i = m;
    exp_q.delete(); tag_q.delete(); tag3_q.delete();
    #1;
    chk("R10", "lanes in reset", 32'(lane_o), 32'h0);
    chk("R10", "clock lane in reset", 32'(clk_lane_o), 32'h1);
    chk("R10", "load in reset", 32'(load_o), 32'h0);
    repeat (3) @(negedge clk_i);
    rst_ni   = 1'b1;
    cur_mode = (m == 2'd3) ? 0 : int'(m);
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!load_o && n < 20);
    chk("R1", "cycles to first slot 6", 32'(n), 32'd6);
  endtask

  task automatic send_pixel(input logic [7:0] r, input logic [7:0] g,
                            input logic [7:0] b, input logic [3:0] c,
                            input string t, input string t3);
    do @(negedge clk_i); while (!load_o);
    red_i = r; grn_i = g; blu_i = b;
    {spare_i, de_i, vsync_i, hsync_i} = c;
    for (int s = 0; s < 7; s++) begin
      exp_t e;
      for (int l = 0; l < 4; l++) e.lanes[l] = exp_bit(cur_mode, l, s, r, g, b, c);
      e.clk  = (s < 2) || (s > 4);
      e.load = (s == 6);
      exp_q.push_back(e);
      tag_q.push_back(t);
      tag3_q.push_back(t3);
    end
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
  endtask

  task automatic burst(input string t, input string t3);
    send_pixel(8'hFF, 8'hFF, 8'hFF, 4'hF, t, t3);
    send_pixel(8'h00, 8'h00, 8'h00, 4'h0, t, t3);
    for (int i = 0; i < 8; i++)
      send_pixel(8'(1 << i), 8'(8'h80 >> i), 8'(i * 37 + 5), 4'(i), t, t3);
    send_pixel(8'hA5, 8'h3C, 8'hC3, 4'h5, t, t3);
    send_pixel(8'h5A, 8'hC3, 8'h3C, 4'hA, t, t3);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    total++; bad++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R3, R4: 18-bit placement, lane 3 quiet, top colour bits ignored
    do_reset(2'd0);
    burst("R3", "R4");
    send_pixel(8'hC0, 8'hC0, 8'hC0, 4'h0, "R4", "R4");
    send_pixel(8'hC1, 8'h40, 8'h80, 4'h0, "R4", "R4");
    drain();

    // R9: mode changes after reset are ignored
    mode_i = 2'd1;
    burst("R9", "R9");
    mode_i = 2'd2;
    send_pixel(8'hF0, 8'h0F, 8'hCC, 4'h9, "R9", "R9");
    drain();

    // R5, R6: 24-bit, low bits on lane 3
    do_reset(2'd1);
    burst("R5", "R6");
    drain();

    // R7, R8: 24-bit, high bits on lane 3
    do_reset(2'd2);
    burst("R7", "R8");
    drain();

    // R9: reserved encoding acts as 18-bit
    do_reset(2'd3);
    send_pixel(8'hFF, 8'h00, 8'hFF, 4'hF, "R9", "R9");
    send_pixel(8'h3F, 8'hC0, 8'h81, 4'h8, "R9", "R9");
    drain();

    // R10: reset dropped into the middle of a pixel
    do_reset(2'd2);
    send_pixel(8'hFF, 8'hFF, 8'hFF, 4'hF, "R7", "R8");
    repeat (3) @(negedge clk_i);
    do_reset(2'd1);
    send_pixel(8'h81, 8'h42, 8'h24, 4'h6, "R5", "R6");
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule